// File: doc/BRIEF.md
# Buffered Two-Wire Burst Master

This block is a two-wire (I2C) bus master for small read-mostly targets, such as the timing descriptor store in a display. Software sets up the transfer through a byte-wide register window. It loads a target address byte, a byte count and up to sixteen buffered bytes. A single command then runs the whole transfer: a start condition, the address byte, and count+1 data bytes moved to or from the buffer, beginning at buffer index 0.

The stop condition is a separate command. This lets software chain transfers through a repeated start, for example a pointer write followed by a read. Status reports a live busy flag, a sticky error flag and a completion flag. The bus pins are open drain: the block only ever pulls SCL or SDA low, or releases them. One bit cell lasts four quarter periods of `QDIV` system clocks each.

Register offsets: 0x00 count, 0x01 control (reads as zero), 0x02 status on read and error-reset on write, 0x03 target address, 0x04 to 0x13 buffer entries 0 to 15.

Top module: `ddc_burst_master`

## Requirements
- R1: After reset, every register reads zero and neither SCL nor SDA is pulled low.
- R2: The count register keeps only bits 3:0 of a write. Bits 7:4 read as zero.
- R3: The address register at 0x03 reads back all 8 bits. Offsets 0x14 to 0x1F read zero, and writes to them change nothing.
- R4: When address bit 0 is 0, a control write with bit 0 (enable) and bit 2 (go) set sends a start, the address byte, and buffer entries 0..count in index order. Each of these bytes is acknowledged by the target.
- R5: When address bit 0 is 1, the same command reads count+1 bytes into buffer entries 0..count. It acknowledges every byte except the last, which it leaves unacknowledged. Entries above count keep their values.
- R6: If the address byte is not acknowledged, status bit 2 (error) is set, no data byte is moved, and the buffer is unchanged.
- R7: If a written data byte is not acknowledged, the transfer stops there, status bit 2 is set, and status bit 3 (complete) is not set.
- R8: A transfer that finishes every byte leaves status at exactly 0x08. Any earlier error is cleared.
- R9: A control write with bit 0 set and bit 2 clear produces a stop condition on the bus and clears status bit 2.
- R10: A control write with bit 0 clear has no effect on the bus or on status.
- R11: A write to offset 0x02 with bit 2 clear clears status bit 2. With bit 2 set, status is unchanged.
- R12: Status bit 0 (busy) reads 1 from the cycle after a go or stop command until that operation ends. Control writes made while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr, combinational |
| sda_in | input | 1 | Sampled level of the SDA line |
| scl_drive_low | output | 1 | Pull SCL low when 1, release when 0 |
| sda_drive_low | output | 1 | Pull SDA low when 1, release when 0 |

## Verification
Software register writes can arrive in the same cycle as sequencer activity. Examples are a second go or stop command, or an error-reset write, issued while a transfer is still moving bytes, or a buffer write made while the sequencer stores a received byte. The bench issues control writes right after launching a transfer. It then judges them by the number of start and stop conditions its behavioural target model sees, and by the final status. The checker covers the status outcome when a hardware completion or failure lands on the same cycle as an error-reset write.

// File: rtl/ddc_pkg.sv
package ddc_pkg;

  localparam int unsigned OFF_COUNT = 0;
  localparam int unsigned OFF_CTRL  = 1;
  localparam int unsigned OFF_STAT  = 2;
  localparam int unsigned OFF_ADDR  = 3;
  localparam int unsigned OFF_DATA  = 4;

  typedef enum logic [1:0] {OP_START, OP_BYTE, OP_STOP} bus_op_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_START, SQ_ADDR, SQ_DATA, SQ_STOP
  } seq_state_e;

  // Line drive for one quarter of a bus operation: {scl_low, sda_low}.
  // SDA only moves while SCL is low, except the start and stop edges.
  function automatic logic [1:0] quarter_drive(bus_op_e op, logic [1:0] q,
                                               logic bit_val, logic sda_prev);
    logic [1:0] d;
    case (op)
      OP_START: case (q)
        2'd0:    d = 2'b10;
        2'd1:    d = 2'b00;
        2'd2:    d = 2'b01;
        default: d = 2'b11;
      endcase
      OP_STOP: case (q)
        2'd0:    d = {1'b1, sda_prev};
        2'd1:    d = 2'b11;
        2'd2:    d = 2'b01;
        default: d = 2'b00;
      endcase
      default: d = {(q == 2'd0 || q == 2'd3), !bit_val};
    endcase
    return d;
  endfunction

  function automatic logic in_buffer(int unsigned off, int unsigned nbytes);
    return (off >= OFF_DATA) && (off < OFF_DATA + nbytes);
  endfunction

  function automatic logic [7:0] status_byte(logic cmp, logic err, logic busy);
    return {4'b0000, cmp, err, 1'b0, busy};
  endfunction

endpackage

// File: rtl/ddc_tick_gen.sv
module ddc_tick_gen #(
  parameter int unsigned QDIV = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = $clog2(QDIV + 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == CW'(QDIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run || tick) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ddc_bit_engine.sv
module ddc_bit_engine
  import ddc_pkg::*;
#(
  parameter int unsigned QDIV = 250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_valid,
  input  bus_op_e    op,
  input  logic [8:0] tx9,
  input  logic       sda_in,
  output logic       op_done,
  output logic [8:0] rx9,
  output logic       scl_low,
  output logic       sda_low
);
  logic       busy_q, done_q, tick;
  bus_op_e    op_q;
  logic [1:0] qtr_q;
  logic [3:0] bitno_q;
  logic [8:0] sh_q, rx_q;
  logic       scl_low_q, sda_low_q;
  logic       more_bits;

  ddc_tick_gen #(.QDIV(QDIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy_q), .tick(tick)
  );

  assign more_bits = (op_q == OP_BYTE) && (bitno_q != 4'd8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; done_q <= 1'b0; op_q <= OP_START; qtr_q <= '0;
      bitno_q <= '0; sh_q <= '0; rx_q <= '0;
      scl_low_q <= 1'b0; sda_low_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (op_valid) begin
          busy_q  <= 1'b1;
          op_q    <= op;
          qtr_q   <= 2'd0;
          bitno_q <= '0;
          sh_q    <= tx9;
          {scl_low_q, sda_low_q} <= quarter_drive(op, 2'd0, tx9[8], sda_low_q);
        end
      end else if (tick) begin
        if (qtr_q == 2'd2) rx_q <= {rx_q[7:0], sda_in};
        if (qtr_q == 2'd3) begin
          if (more_bits) begin
            bitno_q <= bitno_q + 1'b1;
            sh_q    <= {sh_q[7:0], 1'b1};
            qtr_q   <= 2'd0;
            {scl_low_q, sda_low_q} <= quarter_drive(op_q, 2'd0, sh_q[7], sda_low_q);
          end else begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end else begin
          qtr_q <= qtr_q + 2'd1;
          {scl_low_q, sda_low_q} <= quarter_drive(op_q, qtr_q + 2'd1, sh_q[8], sda_low_q);
        end
      end
    end
  end

  assign op_done = done_q;
  assign rx9     = rx_q;
  assign scl_low = scl_low_q;
  assign sda_low = sda_low_q;
endmodule

// File: rtl/ddc_burst_master.sv
module ddc_burst_master
  import ddc_pkg::*;
#(
  parameter int unsigned QDIV      = 250,
  parameter int unsigned BUF_BYTES = 16,
  parameter int unsigned AW        = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          sda_in,
  output logic          scl_drive_low,
  output logic          sda_drive_low
);
  localparam int unsigned IDX_W = $clog2(BUF_BYTES);

  seq_state_e       state_q;
  logic [IDX_W-1:0] cnt_q, idx_q, sw_idx;
  logic [7:0]       addr_q;
  logic [7:0]       data_q [BUF_BYTES];
  logic             err_q, cmp_q, pend_q;

  logic       busy, wr_ctrl, txn_launch, stop_launch, reading, last_idx;
  logic       eng_done, addr_nack, data_nack, txn_fail, txn_ok, rx_store;
  logic       sw_data_we;
  logic [8:0] tx9, rx9;
  bus_op_e    op_sel;

  // Named events used by the sequencer and the bound checker.
  assign busy        = (state_q != SQ_IDLE);
  assign wr_ctrl     = reg_we && (reg_addr == AW'(OFF_CTRL));
  assign txn_launch  = wr_ctrl && !busy && reg_wdata[0] && reg_wdata[2];
  assign stop_launch = wr_ctrl && !busy && reg_wdata[0] && !reg_wdata[2];
  assign reading     = addr_q[0];
  assign last_idx    = (idx_q == cnt_q);
  assign addr_nack   = eng_done && (state_q == SQ_ADDR) && rx9[0];
  assign data_nack   = eng_done && (state_q == SQ_DATA) && !reading && rx9[0];
  assign txn_fail    = addr_nack || data_nack;
  assign txn_ok      = eng_done && (state_q == SQ_DATA) && !data_nack && last_idx;
  assign rx_store    = eng_done && (state_q == SQ_DATA) && reading;
  assign sw_data_we  = reg_we && in_buffer(int'(reg_addr), BUF_BYTES);
  assign sw_idx      = IDX_W'(reg_addr - AW'(OFF_DATA));

  always_comb begin
    case (state_q)
      SQ_START: op_sel = OP_START;
      SQ_STOP:  op_sel = OP_STOP;
      default:  op_sel = OP_BYTE;
    endcase
    case (state_q)
      SQ_ADDR: tx9 = {addr_q, 1'b1};
      SQ_DATA: tx9 = reading ? {8'hFF, last_idx} : {data_q[idx_q], 1'b1};
      default: tx9 = 9'h1FF;
    endcase
  end

  ddc_bit_engine #(.QDIV(QDIV)) u_eng (
    .clk(clk), .rst_n(rst_n), .op_valid(pend_q), .op(op_sel), .tx9(tx9),
    .sda_in(sda_in), .op_done(eng_done), .rx9(rx9),
    .scl_low(scl_drive_low), .sda_low(sda_drive_low)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE; cnt_q <= '0; idx_q <= '0; addr_q <= '0;
      err_q <= 1'b0; cmp_q <= 1'b0; pend_q <= 1'b0;
    end else begin
      pend_q <= 1'b0;
      if (reg_we && reg_addr == AW'(OFF_COUNT)) cnt_q  <= reg_wdata[IDX_W-1:0];
      if (reg_we && reg_addr == AW'(OFF_ADDR))  addr_q <= reg_wdata;
      if (reg_we && reg_addr == AW'(OFF_STAT) && !reg_wdata[2]) err_q <= 1'b0;
      if (txn_launch) begin
        state_q <= SQ_START; idx_q <= '0; pend_q <= 1'b1;
      end
      if (stop_launch) begin
        state_q <= SQ_STOP; pend_q <= 1'b1; err_q <= 1'b0;
      end
      if (eng_done) begin
        case (state_q)
          SQ_START: begin state_q <= SQ_ADDR; pend_q <= 1'b1; end
          SQ_ADDR:
            if (addr_nack) begin state_q <= SQ_IDLE; err_q <= 1'b1; end
            else begin state_q <= SQ_DATA; idx_q <= '0; pend_q <= 1'b1; end
          SQ_DATA:
            if (data_nack) begin state_q <= SQ_IDLE; err_q <= 1'b1; end
            else if (last_idx) begin state_q <= SQ_IDLE; err_q <= 1'b0; cmp_q <= 1'b1; end
            else begin idx_q <= idx_q + 1'b1; pend_q <= 1'b1; end
          default: state_q <= SQ_IDLE;
        endcase
      end
    end
  end

  // Buffer entries: a received byte wins over a software write in the same cycle.
  for (genvar g = 0; g < BUF_BYTES; g++) begin : g_buf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   data_q[g] <= '0;
      else if (rx_store && idx_q == IDX_W'(g))      data_q[g] <= rx9[8:1];
      else if (sw_data_we && sw_idx == IDX_W'(g))   data_q[g] <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_addr == AW'(OFF_COUNT))               reg_rdata = 8'(cnt_q);
    else if (reg_addr == AW'(OFF_STAT))           reg_rdata = status_byte(cmp_q, err_q, busy);
    else if (reg_addr == AW'(OFF_ADDR))           reg_rdata = addr_q;
    else if (in_buffer(int'(reg_addr), BUF_BYTES)) reg_rdata = data_q[sw_idx];
  end
endmodule

// File: rtl/ddc_burst_master_chk.sv
module ddc_burst_master_chk #(
  parameter int unsigned AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic [7:0]    reg_wdata,
  input logic [7:0]    reg_rdata,
  input logic          busy,
  input logic          txn_launch,
  input logic          stop_launch,
  input logic          txn_ok,
  input logic          txn_fail,
  input logic          err_q,
  input logic          cmp_q
);
  AST_COUNT_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == AW'(0)) |-> (reg_rdata[7:4] == 4'h0)); // R2
  AST_LAUNCH_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_launch || stop_launch) |-> !busy); // R12
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({txn_launch, stop_launch, txn_ok, txn_fail})); // R12
  AST_OK_ONLY_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
    txn_ok |=> (cmp_q && !err_q)); // R8
  AST_FAIL_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    txn_fail |=> err_q); // R6
  AST_STOP_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    stop_launch |=> !err_q); // R9
  AST_RSTREG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == AW'(2) && !reg_wdata[2] && !txn_fail) |=> !err_q); // R11
  AST_RSTREG_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == AW'(2) && reg_wdata[2] && !txn_fail && !txn_ok)
    |=> $stable(err_q)); // R11
endmodule

bind ddc_burst_master ddc_burst_master_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
  .txn_launch(txn_launch), .stop_launch(stop_launch), .txn_ok(txn_ok),
  .txn_fail(txn_fail), .err_q(err_q), .cmp_q(cmp_q)
);

// File: tb/ddc_burst_master_tb_top.sv
module ddc_burst_master_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       scl_drive_low, sda_drive_low;
  logic       slv_low = 1'b0;
  logic       scl_line, sda_line;

  int n_chk = 0, n_fail = 0;
  int starts = 0, stops = 0, rd_bytes = 0;

  // Reference register model.
  int   m_cnt = 0, m_addr = 0;
  logic m_err = 0, m_cmp = 0;
  int   m_data [16];

  // Behavioural bus target at device address 0x50.
  logic [7:0] mem [256];
  logic prev_scl = 1'b1, prev_sda = 1'b1;
  logic active = 0, rd_mode = 0, first = 0, mack = 0;
  int   bc = 0, ph = 0;
  logic [7:0] sh = '0, tx = '0, ptr = '0;

  always #5 clk = ~clk;

  assign scl_line = !scl_drive_low;
  assign sda_line = !(sda_drive_low || slv_low);

  ddc_burst_master #(.QDIV(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sda_in(sda_line),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low)
  );

  function automatic logic [7:0] pat(int i);
    return 8'((i * 7 + 3) & 255);
  endfunction

  always @(scl_line, sda_line) begin
    if (scl_line && prev_scl && prev_sda && !sda_line) begin
      active = 1; bc = 0; ph = 0; slv_low = 0; starts++;
    end else if (scl_line && prev_scl && !prev_sda && sda_line) begin
      active = 0; slv_low = 0; stops++;
    end else if (scl_line && !prev_scl && active) begin
      bc++;
      if (bc <= 8) sh = {sh[6:0], sda_line};
      if (bc == 9 && ph == 2) mack = !sda_line;
    end else if (!scl_line && prev_scl && active) begin
      if (bc == 8) begin
        slv_low = 0;
        if (ph == 0) begin
          if (sh[7:1] == 7'h50) begin rd_mode = sh[0]; slv_low = 1; end
          else active = 0;
        end else if (ph == 1 && sh != 8'hEE) begin
          slv_low = 1;
          if (first) begin ptr = sh; first = 0; end
          else begin mem[ptr] = sh; ptr++; end
        end
      end else if (bc == 9) begin
        bc = 0; slv_low = 0;
        if (ph == 0) begin
          if (rd_mode) begin ph = 2; tx = mem[ptr]; ptr++; slv_low = !tx[7]; rd_bytes++; end
          else begin ph = 1; first = 1; end
        end else if (ph == 2) begin
          if (mack) begin tx = mem[ptr]; ptr++; slv_low = !tx[7]; rd_bytes++; end
          else active = 0;
        end
      end else if (ph == 2 && bc >= 1 && bc <= 7) begin
        slv_low = !tx[7 - bc];
      end
    end
    prev_scl = scl_line; prev_sda = sda_line;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); reg_we = 1; reg_addr = 5'(a); reg_wdata = 8'(d);
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk); reg_addr = 5'(a); #1 d = reg_rdata;
  endtask

  task automatic check_all(input string tag);
    int v;
    rd(0, v); chk({tag, " count"}, v, m_cnt);
    rd(1, v); chk({tag, " ctrl"}, v, 0);
    rd(2, v); chk({tag, " status"}, v, {m_cmp, m_err, 2'b00});
    rd(3, v); chk({tag, " addr"}, v, m_addr);
    for (int i = 0; i < 16; i++) begin
      rd(4 + i, v); chk({tag, " data"}, v, m_data[i]);
    end
  endtask

  task automatic wait_idle();
    int v;
    do rd(2, v); while (v[0]);
  endtask

  task automatic set_data(input int i, input int d);
    wr(4 + i, d); m_data[i] = d;
  endtask

  task automatic run_txn(input int a, input int c);
    wr(3, a); m_addr = a;
    wr(0, c); m_cnt = c & 15;
    wr(1, 8'h05);
    wait_idle();
  endtask

  task automatic do_stop();
    wr(1, 8'h01); m_err = 0;
    wait_idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int v, s0, p0, r0;
    for (int i = 0; i < 256; i++) mem[i] = pat(i);
    for (int i = 0; i < 16; i++) m_data[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    check_all("R1");
    chk("R1 scl released", int'(scl_drive_low), 0);
    chk("R1 sda released", int'(sda_drive_low), 0);

    // R2: count keeps low nibble
    wr(0, 8'hF3); m_cnt = 3;
    rd(0, v); chk("R2 count nibble", v, 3);

    // R3: address readback, unmapped offsets
    wr(3, 8'hA5); m_addr = 8'hA5;
    for (int a = 20; a < 32; a++) wr(a, 8'hFF);
    rd(20, v); chk("R3 unmapped read", v, 0);
    rd(31, v); chk("R3 unmapped read", v, 0);
    check_all("R3");

    // R7: data byte refused aborts without complete
    set_data(0, 8'h50); set_data(1, 8'hEE); set_data(2, 8'h99);
    run_txn(8'hA0, 2); m_err = 1;
    check_all("R7");
    chk("R7 later byte not sent", int'(mem[8'h50]), int'(pat(8'h50)));
    s0 = stops;
    do_stop();
    chk("R9 stop seen", stops, s0 + 1);
    check_all("R9");

    // R4 and R12: write burst, control writes while busy ignored
    set_data(0, 8'h10); set_data(1, 8'h55); set_data(2, 8'h66); set_data(3, 8'h77);
    s0 = starts; p0 = stops;
    wr(3, 8'hA0); m_addr = 8'hA0; wr(0, 3); m_cnt = 3;
    wr(1, 8'h05);
    rd(2, v); chk("R12 busy", v & 1, 1);
    wr(1, 8'h05); wr(1, 8'h01);
    wait_idle(); m_cmp = 1;
    chk("R12 one start", starts, s0 + 1);
    chk("R12 no stop", stops, p0);
    chk("R4 mem10", int'(mem[8'h10]), 8'h55);
    chk("R4 mem11", int'(mem[8'h11]), 8'h66);
    chk("R4 mem12", int'(mem[8'h12]), 8'h77);
    check_all("R4");

    // R5: read of three bytes, last one left unacknowledged
    set_data(0, 8'h30); run_txn(8'hA0, 0);
    r0 = rd_bytes;
    run_txn(8'hA1, 2);
    for (int i = 0; i < 3; i++) m_data[i] = pat(8'h30 + i);
    chk("R5 bytes served", rd_bytes, r0 + 3);
    check_all("R5");
    do_stop();

    // R5: full sixteen-byte read
    set_data(0, 8'h40); run_txn(8'hA0, 0);
    r0 = rd_bytes;
    run_txn(8'hA1, 15);
    for (int i = 0; i < 16; i++) m_data[i] = pat(8'h40 + i);
    chk("R5 sixteen bytes", rd_bytes, r0 + 16);
    check_all("R5 full");
    do_stop();

    // R6: address not acknowledged
    r0 = rd_bytes;
    run_txn(8'hB1, 3); m_err = 1;
    chk("R6 no data moved", rd_bytes, r0);
    check_all("R6");

    // R11: reset register
    wr(2, 8'h04);
    rd(2, v); chk("R11 bit2 set keeps", v, 8'h0C);
    wr(2, 8'h00); m_err = 0;
    rd(2, v); chk("R11 bit2 clear clears", v, 8'h08);

    // R10: enable clear has no effect
    run_txn(8'hB0, 0); m_err = 1;
    s0 = starts; p0 = stops;
    wr(1, 8'h04); wr(1, 8'h00);
    repeat (20) @(negedge clk);
    chk("R10 no start", starts, s0);
    chk("R10 no stop", stops, p0);
    check_all("R10");

    // R8: success overwrites error
    set_data(0, 8'h60); set_data(1, 8'h5A);
    run_txn(8'hA0, 1); m_err = 0; m_cmp = 1;
    rd(2, v); chk("R8 status only complete", v, 8'h08);
    chk("R8 byte landed", int'(mem[8'h60]), 8'h5A);
    do_stop();
    check_all("R8");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule